// File: doc/BRIEF.md
# Sidepanel and Blanking Inserter

This block sits on the display-side luma/chroma sample stream, one sample per display clock. It measures each sample's horizontal position from the last rising edge of a horizontal reference, and its line number from the last rising edge of a vertical reference. From those positions it decides, sample by sample, whether to pass the picture through, paint a programmable sidepanel colour over it, or force the blanking levels. Every output is registered, so the result appears exactly one clock after the input sample.

Sidepanels frame a narrower picture, for example a 4:3 source shown on a wide screen. Each sidepanel edge is set as a coarse value in steps of four clocks plus a fine offset of zero to three clocks. Inside the sidepanel the luma is replaced completely. Only the upper four bits of each chroma sample are replaced, and the lower bits pass through. Blanking is the OR of a horizontal window, measured in pixels, and a vertical window, measured in lines. Blanking overrides the sidepanel. Picture luma either passes unchanged, which keeps 9-bit nominal video with headroom inside the 10-bit word, or is doubled to fill the full 10-bit range, with any excess clipped.

Top module: `panel_blank_inserter`

## Requirements
- R1: While reset is asserted and on the first clock after it, `y_out`, `u_out` and `v_out` are all zero.
- R2: The sample presented in the clock where `href` rises (it was low in the previous clock) has pixel position 0. Each later clock adds 1, saturating at 4095. `href` staying high does not restart the count. After reset and before the first rise, the position is 4095.
- R3: A rising edge of `vref` sets the line number to 0. This holds even when `href` rises in the same clock. Otherwise each rising edge of `href` adds 1 to the line number, saturating at 1023. After reset the line number is 1023.
- R4: The sidepanel is active for pixel positions p with 4*`sp_start_crs`+`sp_start_fine` <= p < 4*`sp_stop_crs`+`sp_stop_fine`.
- R5: Inside the sidepanel, and outside blanking, `y_out` equals `sp_y`. Bits [7:4] of `u_out` and `v_out` equal `sp_u` and `sp_v`, and bits [3:0] equal the incoming chroma bits [3:0].
- R6: Pixel positions p with `hb_set` <= p < `hb_clr` are blanked: `y_out` = 64, `u_out` = 0 and `v_out` = 0 (two's complement zero).
- R7: Every sample on a line n with `vb_set` <= n < `vb_clr` is blanked in the same way.
- R8: When blanking and the sidepanel are both active, the blanking values are output.
- R9: Outside the sidepanel and blanking, with `full_range` = 0, `y_out` equals the input luma unchanged.
- R10: Outside the sidepanel and blanking, with `full_range` = 1, `y_out` is twice the input luma, clipped to 1023. Chroma passes unchanged in both range modes.
- R11: Each output reflects the inputs and configuration sampled at the previous rising clock edge. There is exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href | input | 1 | Horizontal reference; its rising edge marks pixel 0 |
| vref | input | 1 | Vertical reference; its rising edge marks line 0 |
| y_in | input | 10 | Luma sample |
| u_in | input | 8 | First chroma sample, two's complement |
| v_in | input | 8 | Second chroma sample, two's complement |
| sp_start_crs | input | 10 | Sidepanel start, units of 4 clocks |
| sp_start_fine | input | 2 | Sidepanel start fine offset, 0 to 3 clocks |
| sp_stop_crs | input | 10 | Sidepanel stop, units of 4 clocks |
| sp_stop_fine | input | 2 | Sidepanel stop fine offset, 0 to 3 clocks |
| sp_y | input | 10 | Sidepanel luma value |
| sp_u | input | 4 | Sidepanel value for the upper 4 bits of the first chroma |
| sp_v | input | 4 | Sidepanel value for the upper 4 bits of the second chroma |
| hb_set | input | 12 | First blanked pixel position |
| hb_clr | input | 12 | First unblanked pixel position after the window |
| vb_set | input | 10 | First blanked line |
| vb_clr | input | 10 | First unblanked line after the window |
| full_range | input | 1 | 1: double luma and clip; 0: pass luma unchanged |
| y_out | output | 10 | Registered luma output |
| u_out | output | 8 | Registered first chroma output |
| v_out | output | 8 | Registered second chroma output |

## Verification
Directed frames place a sidepanel on fine offsets 3 and 1, so that the single positions on either side of each edge show whether the coarse and fine parts are combined correctly. They also overlap a horizontal blanking window with the sidepanel, which exercises blanking priority. Random frames vary line length, reference pulse width, window positions, sidepanel colours and range mode. The random luma values cover both halves of the code range, so the doubling path and the clipping path are both exercised. Reference pulses held high for several clocks, and lines sent before any vertical edge, separate true edge detection from level detection and test the saturated reset values of the counters.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  // Source selection for one output sample, in priority order.
  typedef enum logic [1:0] {
    FILL_PIC   = 2'd0,
    FILL_PANEL = 2'd1,
    FILL_BLANK = 2'd2
  } fill_e;

endpackage

// File: rtl/pbi_timebase.sv
module pbi_timebase #(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          href,
  input  logic          vref,
  output logic [PW-1:0] pix_pos,
  output logic [LW-1:0] line_pos
);

  localparam logic [PW-1:0] PIX_MAX = '1;
  localparam logic [LW-1:0] LIN_MAX = '1;

  logic          href_d, vref_d;
  logic          href_rise, vref_rise;
  logic [PW-1:0] pix_q;
  logic [LW-1:0] lin_q;

  function automatic logic [PW-1:0] pix_adv(input logic [PW-1:0] q);
    return (q == PIX_MAX) ? q : q + 1'b1;
  endfunction

  function automatic logic [LW-1:0] lin_adv(input logic [LW-1:0] q);
    return (q == LIN_MAX) ? q : q + 1'b1;
  endfunction

  assign href_rise = href & ~href_d;
  assign vref_rise = vref & ~vref_d;

  always_comb begin
    pix_pos  = href_rise ? '0 : pix_adv(pix_q);
    if (vref_rise)      line_pos = '0;
    else if (href_rise) line_pos = lin_adv(lin_q);
    else                line_pos = lin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      href_d <= 1'b0;
      vref_d <= 1'b0;
      pix_q  <= PIX_MAX;
      lin_q  <= LIN_MAX;
    end else begin
      href_d <= href;
      vref_d <= vref;
      pix_q  <= pix_pos;
      lin_q  <= line_pos;
    end
  end

  // R2
  pix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    href_rise |=> pix_q == '0);

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!href_rise && pix_pos != PIX_MAX) ##1 !href_rise |-> pix_pos == $past(pix_pos) + 1'b1);

  // R3
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vref_rise |=> lin_q == '0);

  // R3
  line_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (href_rise && !vref_rise && lin_q != LIN_MAX) |=> lin_q == $past(lin_q) + 1'b1);

endmodule

// File: rtl/pbi_window.sv
module pbi_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);

  // Half-open span: lo included, hi excluded.
  function automatic logic in_span(input logic [W-1:0] p,
                                   input logic [W-1:0] a,
                                   input logic [W-1:0] b);
    return (p >= a) && (p < b);
  endfunction

  assign hit = in_span(pos, lo, hi);

endmodule

// File: rtl/pbi_mixer.sv
module pbi_mixer
  import pbi_pkg::*;
#(
  parameter int YW   = 10,
  parameter int CW   = 8,
  parameter int NMSB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fill_e           sel,
  input  logic            full_range,
  input  logic [YW-1:0]   y_in,
  input  logic [CW-1:0]   u_in,
  input  logic [CW-1:0]   v_in,
  input  logic [YW-1:0]   panel_y,
  input  logic [NMSB-1:0] panel_u,
  input  logic [NMSB-1:0] panel_v,
  output logic [YW-1:0]   y_out,
  output logic [CW-1:0]   u_out,
  output logic [CW-1:0]   v_out
);

  localparam logic [YW-1:0] BLANK_Y = YW'(64);
  localparam logic [YW-1:0] Y_MAX   = '1;
  localparam int            NLOW    = CW - NMSB;

  logic [YW-1:0] y_nx;
  logic [CW-1:0] u_nx, v_nx;
  logic [CW-1:0] u_panel, v_panel;

  // Doubling to full scale; anything at or above half scale clips.
  function automatic logic [YW-1:0] scale_luma(input logic [YW-1:0] y,
                                               input logic full);
    logic [YW:0] dbl;
    dbl = {y, 1'b0};
    if (!full)       return y;
    if (y[YW-1])     return Y_MAX;
    return dbl[YW-1:0];
  endfunction

  generate
    if (NLOW > 0) begin : g_keep_low
      assign u_panel = {panel_u, u_in[NLOW-1:0]};
      assign v_panel = {panel_v, v_in[NLOW-1:0]};
    end else begin : g_full_swap
      assign u_panel = CW'(panel_u);
      assign v_panel = CW'(panel_v);
    end
  endgenerate

  always_comb begin
    unique case (sel)
      FILL_BLANK: begin
        y_nx = BLANK_Y;
        u_nx = '0;
        v_nx = '0;
      end
      FILL_PANEL: begin
        y_nx = panel_y;
        u_nx = u_panel;
        v_nx = v_panel;
      end
      default: begin
        y_nx = scale_luma(y_in, full_range);
        u_nx = u_in;
        v_nx = v_in;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out <= '0;
      u_out <= '0;
      v_out <= '0;
    end else begin
      y_out <= y_nx;
      u_out <= u_nx;
      v_out <= v_nx;
    end
  end

  // R6
  blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FILL_BLANK) |=> (y_out == BLANK_Y && u_out == '0 && v_out == '0));

  generate
    if (NLOW > 0) begin : g_low_chk
      // R5
      panel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FILL_PANEL) |=> (u_out[NLOW-1:0] == $past(u_in[NLOW-1:0]) &&
                                 v_out[NLOW-1:0] == $past(v_in[NLOW-1:0])));
    end
  endgenerate

  // R9
  luma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FILL_PIC && !full_range) |=> y_out == $past(y_in));

  // R10
  luma_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FILL_PIC && full_range && y_in[YW-1]) |=> y_out == Y_MAX);

endmodule

// File: rtl/panel_blank_inserter.sv
module panel_blank_inserter
  import pbi_pkg::*;
#(
  parameter int YW   = 10,
  parameter int CW   = 8,
  parameter int PW   = 12,
  parameter int LW   = 10,
  parameter int NMSB = 4,
  localparam int CRW = PW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            href,
  input  logic            vref,
  input  logic [YW-1:0]   y_in,
  input  logic [CW-1:0]   u_in,
  input  logic [CW-1:0]   v_in,
  input  logic [CRW-1:0]  sp_start_crs,
  input  logic [1:0]      sp_start_fine,
  input  logic [CRW-1:0]  sp_stop_crs,
  input  logic [1:0]      sp_stop_fine,
  input  logic [YW-1:0]   sp_y,
  input  logic [NMSB-1:0] sp_u,
  input  logic [NMSB-1:0] sp_v,
  input  logic [PW-1:0]   hb_set,
  input  logic [PW-1:0]   hb_clr,
  input  logic [LW-1:0]   vb_set,
  input  logic [LW-1:0]   vb_clr,
  input  logic            full_range,
  output logic [YW-1:0]   y_out,
  output logic [CW-1:0]   u_out,
  output logic [CW-1:0]   v_out
);

  localparam logic [YW-1:0] BLANK_Y = YW'(64);

  logic [PW-1:0] pix_pos;
  logic [LW-1:0] line_pos;
  logic [PW-1:0] sp_lo, sp_hi;
  logic          panel_hit, hb_hit, vb_hit, blank_hit;
  fill_e         sel;

  // Coarse step of four clocks plus fine offset.
  function automatic logic [PW-1:0] edge_pos(input logic [CRW-1:0] crs,
                                             input logic [1:0]     fine);
    return {crs, fine};
  endfunction

  assign sp_lo = edge_pos(sp_start_crs, sp_start_fine);
  assign sp_hi = edge_pos(sp_stop_crs,  sp_stop_fine);

  pbi_timebase #(.PW(PW), .LW(LW)) i_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .href    (href),
    .vref    (vref),
    .pix_pos (pix_pos),
    .line_pos(line_pos)
  );

  pbi_window #(.W(PW)) i_panel_win (
    .pos(pix_pos), .lo(sp_lo), .hi(sp_hi), .hit(panel_hit)
  );

  pbi_window #(.W(PW)) i_hblank_win (
    .pos(pix_pos), .lo(hb_set), .hi(hb_clr), .hit(hb_hit)
  );

  pbi_window #(.W(LW)) i_vblank_win (
    .pos(line_pos), .lo(vb_set), .hi(vb_clr), .hit(vb_hit)
  );

  assign blank_hit = hb_hit | vb_hit;

  always_comb begin
    if (blank_hit)      sel = FILL_BLANK;
    else if (panel_hit) sel = FILL_PANEL;
    else                sel = FILL_PIC;
  end

  pbi_mixer #(.YW(YW), .CW(CW), .NMSB(NMSB)) i_mixer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .full_range(full_range),
    .y_in      (y_in),
    .u_in      (u_in),
    .v_in      (v_in),
    .panel_y   (sp_y),
    .panel_u   (sp_u),
    .panel_v   (sp_v),
    .y_out     (y_out),
    .u_out     (u_out),
    .v_out     (v_out)
  );

  // R8
  blank_over_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_hit && panel_hit) |=> (y_out == BLANK_Y && u_out == '0 && v_out == '0));

  // R4
  panel_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_hit && !blank_hit) |=> y_out == $past(sp_y));

  // R7
  vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vb_hit |=> y_out == BLANK_Y);

endmodule

// File: tb/test_panel_blank_inserter.sv
module test_panel_blank_inserter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       href = 1'b0, vref = 1'b0;
  logic [9:0] y_in = '0;
  logic [7:0] u_in = '0, v_in = '0;
  logic [9:0] sp_start_crs = '0, sp_stop_crs = '0;
  logic [1:0] sp_start_fine = '0, sp_stop_fine = '0;
  logic [9:0] sp_y = '0;
  logic [3:0] sp_u = '0, sp_v = '0;
  logic [11:0] hb_set = '0, hb_clr = '0;
  logic [9:0] vb_set = '0, vb_clr = '0;
  logic       full_range = 1'b0;
  logic [9:0] y_out;
  logic [7:0] u_out, v_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  int  m_pix = 4095;
  int  m_lin = 1023;
  bit  m_hprev = 0, m_vprev = 0;
  bit  pend = 0;
  int  ey, eu, ev;
  string etag;

  always #5 clk = ~clk;

  panel_blank_inserter i_panel_blank_inserter (
    .clk(clk), .rst_n(rst_n), .href(href), .vref(vref),
    .y_in(y_in), .u_in(u_in), .v_in(v_in),
    .sp_start_crs(sp_start_crs), .sp_start_fine(sp_start_fine),
    .sp_stop_crs(sp_stop_crs), .sp_stop_fine(sp_stop_fine),
    .sp_y(sp_y), .sp_u(sp_u), .sp_v(sp_v),
    .hb_set(hb_set), .hb_clr(hb_clr), .vb_set(vb_set), .vb_clr(vb_clr),
    .full_range(full_range),
    .y_out(y_out), .u_out(u_out), .v_out(v_out)
  );

  function automatic int luma_ref(int y, bit full);
    if (!full) return y;
    return (y * 2 > 1023) ? 1023 : y * 2;
  endfunction

  task automatic check3(string tag, int ay, int au, int av, int xy, int xu, int xv);
    checks++;
    if (ay != xy || au != xu || av != xv) begin
      errors++;
      $display("FAIL %s: got y=%0d u=%0d v=%0d, expected y=%0d u=%0d v=%0d",
               tag, ay, au, av, xy, xu, xv);
    end
  endtask

  // One clock: check the previous sample's result (R11), drive a new one.
  task automatic step(input bit h, input bit v);
    int  sp_lo, sp_hi, yr, ur, vr;
    bit  hr, vrr, hb, vb, sp;
    if (pend) check3(etag, y_out, u_out, v_out, ey, eu, ev);
    yr = int'($urandom_range(0, 1023));
    ur = int'($urandom_range(0, 255));
    vr = int'($urandom_range(0, 255));
    href = h; vref = v;
    y_in = yr[9:0]; u_in = ur[7:0]; v_in = vr[7:0];
    // R2 / R3: independent position model
    hr  = h && !m_hprev;
    vrr = v && !m_vprev;
    m_pix = hr ? 0 : ((m_pix == 4095) ? 4095 : m_pix + 1);
    if (vrr)     m_lin = 0;
    else if (hr) m_lin = (m_lin == 1023) ? 1023 : m_lin + 1;
    m_hprev = h; m_vprev = v;
    sp_lo = int'(sp_start_crs) * 4 + int'(sp_start_fine);
    sp_hi = int'(sp_stop_crs) * 4 + int'(sp_stop_fine);
    sp = (m_pix >= sp_lo) && (m_pix < sp_hi);
    hb = (m_pix >= int'(hb_set)) && (m_pix < int'(hb_clr));
    vb = (m_lin >= int'(vb_set)) && (m_lin < int'(vb_clr));
    if (hb || vb) begin
      ey = 64; eu = 0; ev = 0;
      etag = sp ? "R8 blank over panel" : (hb ? "R6 horizontal blank" : "R7 vertical blank");
    end else if (sp) begin
      ey = int'(sp_y);
      eu = int'(sp_u) * 16 + (ur % 16);
      ev = int'(sp_v) * 16 + (vr % 16);
      etag = "R4 R5 sidepanel";
    end else begin
      ey = luma_ref(yr, full_range); eu = ur; ev = vr;
      etag = full_range ? "R10 full range luma" : "R9 headroom luma";
    end
    pend = 1;
    @(negedge clk);
  endtask

  task automatic send_line(int len, int hw, bit vstart);
    for (int p = 0; p < len; p++) step(p < hw, vstart && (p < hw));
  endtask

  task automatic send_frame(int lines, int len, int hw);
    for (int l = 0; l < lines; l++) send_line(len, hw, l == 0);
  endtask

  task automatic rand_cfg();
    sp_start_crs  = 10'($urandom_range(0, 12));
    sp_start_fine = 2'($urandom_range(0, 3));
    sp_stop_crs   = 10'($urandom_range(4, 30));
    sp_stop_fine  = 2'($urandom_range(0, 3));
    sp_y = 10'($urandom_range(0, 1023));
    sp_u = 4'($urandom_range(0, 15));
    sp_v = 4'($urandom_range(0, 15));
    hb_set = 12'($urandom_range(0, 120));
    hb_clr = 12'($urandom_range(0, 130));
    vb_set = 10'($urandom_range(0, 4));
    vb_clr = 10'($urandom_range(0, 6));
    full_range = 1'($urandom_range(0, 1));
  endtask

  initial begin
    void'($urandom(32'd20517));
    // R1: reset state
    repeat (3) @(negedge clk);
    check3("R1 reset", y_out, u_out, v_out, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 first clock after reset", y_out, u_out, v_out, 0, 0, 0);

    // R2/R3: lines before any vertical edge, saturated line count
    vb_set = 10'd0; vb_clr = 10'd2;
    send_line(40, 3, 0);
    send_line(40, 3, 0);

    // R4: fine offsets at both edges (11..12), no blanking
    vb_set = 0; vb_clr = 0; hb_set = 0; hb_clr = 0;
    sp_start_crs = 10'd2; sp_start_fine = 2'd3;
    sp_stop_crs  = 10'd3; sp_stop_fine  = 2'd1;
    sp_y = 10'd900; sp_u = 4'hA; sp_v = 4'h5;
    full_range = 1'b0;
    send_frame(3, 60, 4);
    // R10: full range with the same windows
    full_range = 1'b1;
    send_frame(3, 60, 4);
    // R8: horizontal blank overlapping the panel
    sp_start_crs = 10'd2; sp_start_fine = 2'd0;
    sp_stop_crs  = 10'd8; sp_stop_fine  = 2'd2;
    hb_set = 12'd5; hb_clr = 12'd15;
    send_frame(3, 60, 6);
    // R7: vertical blank on lines 1..2
    vb_set = 10'd1; vb_clr = 10'd3;
    send_frame(5, 50, 2);

    // Constrained random frames
    for (int f = 0; f < 14; f++) begin
      rand_cfg();
      send_frame(8, int'($urandom_range(40, 140)), int'($urandom_range(1, 10)));
    end
    step(0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule